// File: doc/BRIEF.md
# Fractional Chip-Rate Clock Generator

This block runs entirely on a reference clock (nominally 19.68 MHz). It produces two outputs. The first is a chip-rate clock at roughly eight times the spreading chip rate. The second is a divided copy of the reference. In the default mode the chip clock toggles on every reference cycle, except for one reference cycle per frame of `FRAME_LEN` cycles. On that cycle one low phase is held for an extra cycle. The result is exactly `(FRAME_LEN-1)/2` output periods per frame, which is 512 periods per 1025 cycles and about 9.8304 MHz at the default size. The duty is therefore slightly off 50%.

A 2-bit mode field selects one of four chip-clock modes:
- fractional
- external clock passed through
- plain divide-by-two
- off

Two power-state inputs, CDMA sleep and FM idle, force the chip clock low. A small state machine with the states ST_OFF, ST_PARK, ST_FRAC, ST_HALF and ST_EXT controls the chip clock. Its transitions are:
- When the requested state differs from the current one, any state moves to ST_PARK. In ST_PARK the output is low and the frame counter is cleared.
- ST_PARK always moves to the requested state on the next edge.
- A state whose request is unchanged stays where it is.

The requested state is ST_OFF while either power-state input is high. Otherwise it follows the mode field. The divided reference output either divides by `2**REF_DIV_W` (4 by default) or passes the reference through. It can be disabled by its off bit. It is also disabled while the power-down bit and CDMA sleep are both high. A drive-strength select bit is mirrored as a registered status bit.

Top module: `chip_clk_gen`

## Requirements
- R1: While reset is asserted, `chip_clk`, `ref_div_clk` and `drv_status` are 0.
- R2: `ck_mode` = 00, fractional mode.
  - The first edge after the change drives the output low, and the next edge parks it low.
  - After that, the output toggles each edge. On the edge where the frame counter sits at `FRAME_LEN-1` it holds instead.
  - Each `FRAME_LEN`-cycle frame therefore holds `(FRAME_LEN-1)/2` single-cycle high phases and exactly one two-cycle low phase.
- R3: `ck_mode` = 10 makes `chip_clk` toggle on every reference edge once the two-edge entry has passed.
- R4: `ck_mode` = 11 holds `chip_clk` low.
- R5: `ck_mode` = 01 makes `chip_clk` equal `ext_clk` as sampled at the previous reference edge, after the two-edge entry.
- R6: `cdma_sleep` = 1 or `fm_idle` = 1 drives `chip_clk` low from the next edge, whatever the mode.
- R7: When the requested state changes, `chip_clk` is low after that edge and the following one. Fractional mode then restarts at frame position 0 with a high phase.
- R8: Divided reference output ratio.
  - With `refdiv_sel` = 1, `ref_div_clk` repeats two cycles high and two cycles low.
  - With `refdiv_sel` = 0, `ref_div_clk` equals the reference clock, gated by the registered enable.
  - The select takes effect one edge after it is driven.
- R9: `refdiv_off` = 1 holds `ref_div_clk` low from the next edge.
- R10: `pwr_down` = 1 holds `ref_div_clk` low only while `cdma_sleep` = 1. With `cdma_sleep` = 0, `pwr_down` has no effect.
- R11: `drv_status` equals `drv_sel` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_mode | input | 2 | Chip clock mode: 00 fractional, 01 external, 10 divide-by-two, 11 off |
| ext_clk | input | 1 | External chip clock for mode 01 |
| cdma_sleep | input | 1 | Forces the chip clock low; with `pwr_down` also stops the divided output |
| fm_idle | input | 1 | Forces the chip clock low |
| refdiv_sel | input | 1 | 1: divide by 2**REF_DIV_W, 0: divide by 1 |
| refdiv_off | input | 1 | 1 disables the divided reference output |
| pwr_down | input | 1 | Stops the divided output while `cdma_sleep` is high |
| drv_sel | input | 1 | Drive-strength select, reported only |
| chip_clk | output | 1 | Chip-rate clock |
| ref_div_clk | output | 1 | Divided reference output |
| drv_status | output | 1 | Registered copy of `drv_sel` |

## Verification
The bench builds the block with `FRAME_LEN` = 9 and `REF_DIV_W` = 2. A frame wrap therefore lands eleven edges after a mode request. Four complete frames, each with its single stretched low phase, fit in under forty samples. The divide-by-four sequence and the ST_PARK entry into every mode are visible in the same short window. The default 1025-cycle frame uses the same counter compare, only wider.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    typedef enum logic [1:0] {
        CK_FRAC = 2'b00,
        CK_EXT  = 2'b01,
        CK_HALF = 2'b10,
        CK_OFF  = 2'b11
    } ck_mode_e;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_PARK = 3'd1,
        ST_FRAC = 3'd2,
        ST_HALF = 3'd3,
        ST_EXT  = 3'd4
    } ck_state_e;

endpackage

// File: rtl/ccg_frame_fsm.sv
module ccg_frame_fsm
    import ccg_pkg::*;
#(
    parameter int FRAME_LEN = 1025
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       force_low,
    input  logic       ext_clk,
    output logic       chip_clk
);

    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

    ck_state_e        state, nxt, tgt;
    logic [CNT_W-1:0] frm;
    logic             ck_q;

    // requested state from mode field and power-state overrides
    always_comb begin
        tgt = ST_OFF;
        if (!force_low) begin
            unique case (mode)
                CK_FRAC: tgt = ST_FRAC;
                CK_EXT:  tgt = ST_EXT;
                CK_HALF: tgt = ST_HALF;
                CK_OFF:  tgt = ST_OFF;
            endcase
        end
    end

    always_comb begin
        if (state == ST_PARK)
            nxt = tgt;
        else if (state != tgt)
            nxt = ST_PARK;
        else
            nxt = state;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    // output and frame position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q <= 1'b0;
            frm  <= '0;
        end else if (state != tgt) begin
            ck_q <= 1'b0;
            frm  <= '0;
        end else begin
            unique case (state)
                ST_FRAC: begin
                    if (frm == LAST_POS) begin
                        frm <= '0;
                    end else begin
                        frm  <= frm + 1'b1;
                        ck_q <= ~ck_q;
                    end
                end
                ST_HALF: begin
                    ck_q <= ~ck_q;
                    frm  <= '0;
                end
                ST_EXT: begin
                    ck_q <= ext_clk;
                    frm  <= '0;
                end
                default: begin
                    ck_q <= 1'b0;
                    frm  <= '0;
                end
            endcase
        end
    end

    assign chip_clk = ck_q;

endmodule

// File: rtl/ccg_refdiv.sv
module ccg_refdiv #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    input  logic enable,
    output logic div_out
);

    logic [DIV_W-1:0] cnt;
    logic             en_q;
    logic             sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            en_q  <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            en_q  <= enable;
            sel_q <= div_sel;
            cnt   <= enable ? cnt + 1'b1 : '0;
        end
    end

    // top counter bit is a square wave at clk / 2**DIV_W
    assign div_out = sel_q ? cnt[DIV_W-1] : (clk & en_q);

endmodule

// File: rtl/chip_clk_gen.sv
module chip_clk_gen #(
    parameter int FRAME_LEN = 1025,
    parameter int REF_DIV_W = 2
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic [1:0] ck_mode,
    input  logic       ext_clk,
    input  logic       cdma_sleep,
    input  logic       fm_idle,
    input  logic       refdiv_sel,
    input  logic       refdiv_off,
    input  logic       pwr_down,
    input  logic       drv_sel,
    output logic       chip_clk,
    output logic       ref_div_clk,
    output logic       drv_status
);

    logic force_low;
    logic ref_en;

    assign force_low = cdma_sleep | fm_idle;
    assign ref_en    = ~refdiv_off & ~(pwr_down & cdma_sleep);

    ccg_frame_fsm #(.FRAME_LEN(FRAME_LEN)) u_fsm (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .mode      (ck_mode),
        .force_low (force_low),
        .ext_clk   (ext_clk),
        .chip_clk  (chip_clk)
    );

    ccg_refdiv #(.DIV_W(REF_DIV_W)) u_refdiv (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .div_sel (refdiv_sel),
        .enable  (ref_en),
        .div_out (ref_div_clk)
    );

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)
            drv_status <= 1'b0;
        else
            drv_status <= drv_sel;
    end

endmodule

// File: rtl/ccg_checker.sv
module ccg_checker (
    input logic       clk_ref,
    input logic       rst_n,
    input logic [1:0] ck_mode,
    input logic       ext_clk,
    input logic       cdma_sleep,
    input logic       fm_idle,
    input logic       refdiv_sel,
    input logic       refdiv_off,
    input logic       pwr_down,
    input logic       drv_sel,
    input logic       chip_clk,
    input logic       ref_div_clk,
    input logic       drv_status
);

    logic [1:0] age;
    logic [1:0] code;
    logic       ren;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    assign code = (cdma_sleep | fm_idle) ? 2'b11 : ck_mode;
    assign ren  = ~refdiv_off & ~(pwr_down & cdma_sleep);

    AST_FRAC_HIGH_SINGLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age == 2'd3 && $past(code) == 2'b00 && $past(code, 2) == 2'b00 && $past(code, 3) == 2'b00)
        |-> !(chip_clk && $past(chip_clk))); // R2

    AST_HALF_TOGGLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age == 2'd3 && $past(code) == 2'b10 && $past(code, 2) == 2'b10 && $past(code, 3) == 2'b10)
        |-> (chip_clk != $past(chip_clk))); // R3

    AST_OFF_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(code) == 2'b11) |-> !chip_clk); // R4

    AST_EXT_FOLLOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age == 2'd3 && $past(code) == 2'b01 && $past(code, 2) == 2'b01 && $past(code, 3) == 2'b01)
        |-> (chip_clk == $past(ext_clk))); // R5

    AST_FORCE_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(cdma_sleep | fm_idle) |-> !chip_clk); // R6

    AST_CHANGE_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 2'd2 && $past(code) != $past(code, 2)) |-> !chip_clk); // R7

    AST_QUARTER_FLIP: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age == 2'd3 && $past(refdiv_sel) && $past(refdiv_sel, 2) && $past(refdiv_sel, 3)
         && $past(ren) && $past(ren, 2))
        |-> (ref_div_clk != $past(ref_div_clk, 2))); // R8

    AST_REF_OFF: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(refdiv_off) |-> !ref_div_clk); // R9

    AST_PWR_SLEEP: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(pwr_down && cdma_sleep) |-> !ref_div_clk); // R10

    AST_DRV_MIRROR: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age != 2'd0) |-> (drv_status == $past(drv_sel))); // R11

endmodule

bind chip_clk_gen ccg_checker u_chk (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .ck_mode     (ck_mode),
    .ext_clk     (ext_clk),
    .cdma_sleep  (cdma_sleep),
    .fm_idle     (fm_idle),
    .refdiv_sel  (refdiv_sel),
    .refdiv_off  (refdiv_off),
    .pwr_down    (pwr_down),
    .drv_sel     (drv_sel),
    .chip_clk    (chip_clk),
    .ref_div_clk (ref_div_clk),
    .drv_status  (drv_status)
);

// File: tb/sim_chip_clk_gen.sv
module sim_chip_clk_gen;

    localparam int CLK_P     = 10;
    localparam int FRAME_LEN = 9;
    localparam int REF_DIV_W = 2;

    // row: {mode[19:18], sleep[17], fm_idle[16], expected chip_clk per step[15:0]}
    localparam logic [15:0] EXT_PAT = 16'hB1D3;
    localparam int NROWS = 6;
    localparam logic [19:0] ROWS [0:NROWS-1] = '{
        {2'b00, 1'b0, 1'b0, 16'hA954},
        {2'b10, 1'b0, 1'b0, 16'h5554},
        {2'b11, 1'b0, 1'b0, 16'h0000},
        {2'b01, 1'b0, 1'b0, 16'hB1D0},
        {2'b00, 1'b1, 1'b0, 16'h0000},
        {2'b10, 1'b0, 1'b1, 16'h0000}
    };

    logic       clk_ref = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ck_mode = 2'b11;
    logic       ext_clk = 1'b0;
    logic       cdma_sleep = 1'b0;
    logic       fm_idle = 1'b0;
    logic       refdiv_sel = 1'b1;
    logic       refdiv_off = 1'b0;
    logic       pwr_down = 1'b0;
    logic       drv_sel = 1'b0;
    logic       chip_clk;
    logic       ref_div_clk;
    logic       drv_status;

    int total = 0;
    int bad = 0;

    always #(CLK_P / 2) clk_ref = ~clk_ref;

    chip_clk_gen #(.FRAME_LEN(FRAME_LEN), .REF_DIV_W(REF_DIV_W)) u0 (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .ck_mode     (ck_mode),
        .ext_clk     (ext_clk),
        .cdma_sleep  (cdma_sleep),
        .fm_idle     (fm_idle),
        .refdiv_sel  (refdiv_sel),
        .refdiv_off  (refdiv_off),
        .pwr_down    (pwr_down),
        .drv_sel     (drv_sel),
        .chip_clk    (chip_clk),
        .ref_div_clk (ref_div_clk),
        .drv_status  (drv_status)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string row_req(input logic [19:0] r);
        if (r[17] || r[16]) return "R6";
        case (r[19:18])
            2'b00:   return "R2";
            2'b01:   return "R5";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic settle_off();
        ck_mode    = 2'b11;
        cdma_sleep = 1'b0;
        fm_idle    = 1'b0;
        repeat (4) @(negedge clk_ref);
    endtask

    initial begin
        #(CLK_P * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic smp [0:39];
        int   highs;
        int   pairs;

        // R1: reset state
        repeat (2) @(negedge clk_ref);
        chk("R1 chip_clk", chip_clk, 1'b0);
        chk("R1 ref_div_clk", ref_div_clk, 1'b0);
        chk("R1 drv_status", drv_status, 1'b0);
        rst_n = 1'b1;

        // R8: divide-by-four sequence
        repeat (3) @(negedge clk_ref);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk_ref);
            smp[k] = ref_div_clk;
        end
        highs = 0;
        for (int k = 0; k < 8; k++) begin
            chk("R8 quarter flip", smp[k + 2], ~smp[k]);
            if (smp[k]) highs++;
        end
        chk_int("R8 quarter highs", highs, 4);

        // table of mode vectors
        for (int r = 0; r < NROWS; r++) begin
            ck_mode    = ROWS[r][19:18];
            cdma_sleep = ROWS[r][17];
            fm_idle    = ROWS[r][16];
            ext_clk    = EXT_PAT[0];
            for (int i = 0; i < 16; i++) begin
                @(negedge clk_ref);
                chk(row_req(ROWS[r]), chip_clk, ROWS[r][i]);
                if (i < 15) ext_clk = EXT_PAT[i + 1];
            end
            settle_off();
        end

        // R2: long run, four frames
        ck_mode = 2'b00;
        for (int k = 0; k < 38; k++) begin
            @(negedge clk_ref);
            smp[k] = chip_clk;
        end
        highs = 0;
        pairs = 0;
        for (int k = 2; k < 38; k++) begin
            if (smp[k]) highs++;
            if (k < 37 && !smp[k] && !smp[k + 1]) pairs++;
        end
        chk_int("R2 highs per four frames", highs, 16);
        chk_int("R2 stretched lows per four frames", pairs, 4);
        settle_off();

        // R7: mode change while output high
        ck_mode = 2'b10;
        repeat (3) @(negedge clk_ref);
        chk("R7 pre-change high", chip_clk, 1'b1);
        ck_mode = 2'b00;
        @(negedge clk_ref);
        chk("R7 first low", chip_clk, 1'b0);
        @(negedge clk_ref);
        chk("R7 park low", chip_clk, 1'b0);
        @(negedge clk_ref);
        chk("R7 restart high", chip_clk, 1'b1);
        settle_off();

        // R8: divide by one
        refdiv_sel = 1'b0;
        @(posedge clk_ref);
        #1;
        chk("R8 div1 high", ref_div_clk, 1'b1);
        @(negedge clk_ref);
        chk("R8 div1 low", ref_div_clk, 1'b0);

        // R9: off bit
        refdiv_off = 1'b1;
        @(posedge clk_ref);
        #1;
        chk("R9 off div1", ref_div_clk, 1'b0);
        @(negedge clk_ref);
        refdiv_sel = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk_ref);
            chk("R9 off quarter", ref_div_clk, 1'b0);
        end
        refdiv_off = 1'b0;
        refdiv_sel = 1'b0;
        @(negedge clk_ref);

        // R10: power-down only with sleep
        pwr_down = 1'b1;
        @(posedge clk_ref);
        #1;
        chk("R10 pwr_down awake", ref_div_clk, 1'b1);
        @(negedge clk_ref);
        cdma_sleep = 1'b1;
        @(posedge clk_ref);
        #1;
        chk("R10 pwr_down asleep", ref_div_clk, 1'b0);
        @(negedge clk_ref);
        cdma_sleep = 1'b0;
        pwr_down   = 1'b0;
        @(posedge clk_ref);
        #1;
        chk("R10 restored", ref_div_clk, 1'b1);
        @(negedge clk_ref);

        // R11: drive status mirror
        drv_sel = 1'b1;
        @(negedge clk_ref);
        chk("R11 set", drv_status, 1'b1);
        drv_sel = 1'b0;
        @(negedge clk_ref);
        chk("R11 clear", drv_status, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule